// File: doc/BRIEF.md
# Leg Gate Controller with Blanking and Pulse Qualification

This block sits between a modulator and the gate drivers of a three-phase, two-level converter. Each leg has two command inputs, one for the upper switch and one for the lower switch, and each can request its own switch independently. A per-leg state machine turns these requests into two registered gate outputs. It guarantees that the outputs are never high together, and it holds both outputs low for a programmable number of clock cycles whenever conduction moves from one switch to the other.

Before the state machine acts on a new command level, that level must stay unchanged for a programmable number of cycles. Short spikes and short notches therefore never reach the gates. A request for both switches of a leg at once is refused: both gates of that leg are forced low and a sticky per-leg fault bit is raised. The blanking length and the qualification length are shared 8-bit cycle counts. A leg copies them only while it sits idle with both gates off, so a value that changes during conduction cannot disturb a transition that is already under way.

Top module: `gate_ctrl`

## Requirements
- R1: For every leg, `gate_top` and `gate_bot` are never both high in the same cycle.
- R2: When a leg hands over from one switch to the other, the outgoing gate falls and the incoming gate rises exactly max(dead_cnt,1) cycles later, with both gates low in between.
- R3: Command bits are encoded per leg as {top,bot}. The value 10 requests the upper switch and 01 the lower switch. Each leg responds only to its own command pair.
- R4: When a leg's commands are both high for at least one clock edge, both of its gates are low from the second edge after that. A later legal command must then requalify in full before it turns a gate on.
- R5: A leg's `fault` bit rises on the second clock edge after both of its commands are seen high. It stays high until reset, and other legs' fault bits are not affected.
- R6: A command level that lasts fewer than max(min_pulse,1) cycles is ignored. This applies both to a pulse from idle and to a notch during conduction. A level that lasts that long or longer is accepted. A value of 0 behaves as 1.
- R7: Let a new command be applied before clock edge k, with q = max(min_pulse,1) and b = max(dead_cnt,1). A gate turns on at edge k+q+1+b. A request for both gates off takes effect at edge k+q+1.
- R8: `dead_cnt` and `min_pulse` are copied only while a leg is idle with both gates off. A change during conduction has no effect on the next handover. It takes effect once the leg has been idle.
- R9: While `rst` is high and on the edge after it, every gate output and every fault bit is low and each leg is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_top | input | LEGS | Upper-switch request, one bit per leg |
| cmd_bot | input | LEGS | Lower-switch request, one bit per leg |
| dead_cnt | input | CW | Blanking length in clock cycles |
| min_pulse | input | CW | Minimum accepted command level width in cycles |
| gate_top | output | LEGS | Registered upper gate drive |
| gate_bot | output | LEGS | Registered lower gate drive |
| fault | output | LEGS | Sticky illegal-request flag per leg |

## Verification
The bench times both edges of a handover to the cycle. A controller that skipped the blanking state would show the incoming gate too early, and one that counted from the wrong edge would be off by one. It drives notches and pulses one cycle shorter than the threshold and exactly at it. A filter that compared with the wrong bound would pass the short one or drop the exact one, and a threshold of zero that was not clamped would stall the leg.

The bench changes the blanking value while a switch conducts, to catch a controller that copies it continuously. It applies a request for both switches during conduction, to catch a controller that keeps the gate on, that forgets the fault, or that resumes without requalifying. A random phase with rare illegal requests checks overlap, the handover gap and settled levels on all three legs.

// File: rtl/gate_ctrl_pkg.sv
package gate_ctrl_pkg;

    // command pair encoding {top, bot}
    localparam logic [1:0] REQ_NONE = 2'b00;
    localparam logic [1:0] REQ_BOT  = 2'b01;
    localparam logic [1:0] REQ_TOP  = 2'b10;
    localparam logic [1:0] REQ_BAD  = 2'b11;

    typedef enum logic [1:0] {
        LEG_IDLE  = 2'd0,
        LEG_UPPER = 2'd1,
        LEG_LOWER = 2'd2,
        LEG_GAP   = 2'd3
    } leg_state_e;

    function automatic logic [1:0] req_of(input leg_state_e st);
        case (st)
            LEG_UPPER: req_of = REQ_TOP;
            LEG_LOWER: req_of = REQ_BOT;
            default:   req_of = REQ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gate_cmd_qual.sv
module gate_cmd_qual
    import gate_ctrl_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    raw_i,
    input  logic [CW-1:0] min_i,
    output logic [1:0]    req_o,
    output logic          bad_o
);

    typedef struct packed {
        logic [1:0]    raw;
        logic [1:0]    cand;
        logic [1:0]    filt;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t q, d;
    logic [CW-1:0] need;
    logic [CW-1:0] run;

    always_comb begin
        d      = q;
        d.raw  = raw_i;
        d.cand = q.raw;
        need   = (min_i == '0) ? CW'(1) : min_i;
        if (q.raw != q.cand)
            run = CW'(1);
        else if (q.cnt == {CW{1'b1}})
            run = q.cnt;
        else
            run = q.cnt + 1'b1;

        if (q.raw == REQ_BAD) begin
            d.filt = REQ_NONE;
            d.cnt  = '0;
        end else if (q.raw == q.filt) begin
            d.cnt = '0;
        end else if (run >= need) begin
            d.filt = q.raw;
            d.cnt  = '0;
        end else begin
            d.cnt = run;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_o = q.filt;
    assign bad_o = (q.raw == REQ_BAD);

endmodule

// File: rtl/gate_leg_fsm.sv
module gate_leg_fsm
    import gate_ctrl_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    req_i,
    input  logic          bad_i,
    input  logic [CW-1:0] dt_i,
    input  logic [CW-1:0] mp_i,
    output logic [CW-1:0] mp_o,
    output logic          gt_o,
    output logic          gb_o,
    output logic          flt_o
);

    typedef struct packed {
        leg_state_e    st;
        leg_state_e    tgt;
        logic [CW-1:0] cnt;
        logic [CW-1:0] dt;
        logic [CW-1:0] mp;
        logic          gt;
        logic          gb;
        logic          flt;
    } leg_t;

    localparam leg_t LEG_RST = '{
        st: LEG_IDLE, tgt: LEG_IDLE, cnt: '0,
        dt: CW'(1), mp: CW'(1), gt: 1'b0, gb: 1'b0, flt: 1'b0
    };

    leg_t q, d;
    logic [CW:0] gap_len;
    logic        gap_done;

    always_comb begin
        d        = q;
        gap_len  = (q.dt == '0) ? (CW+1)'(1) : {1'b0, q.dt};
        gap_done = ({1'b0, q.cnt} + (CW+1)'(1)) >= gap_len;

        if (q.st == LEG_IDLE) begin
            d.dt = dt_i;
            d.mp = mp_i;
        end

        if (bad_i) begin
            d.st  = LEG_IDLE;
            d.flt = 1'b1;
        end else begin
            case (q.st)
                LEG_IDLE: begin
                    if (req_i == REQ_TOP) begin
                        d.st = LEG_GAP; d.tgt = LEG_UPPER; d.cnt = '0;
                    end else if (req_i == REQ_BOT) begin
                        d.st = LEG_GAP; d.tgt = LEG_LOWER; d.cnt = '0;
                    end
                end
                LEG_UPPER: begin
                    if (req_i == REQ_BOT) begin
                        d.st = LEG_GAP; d.tgt = LEG_LOWER; d.cnt = '0;
                    end else if (req_i == REQ_NONE) begin
                        d.st = LEG_IDLE;
                    end
                end
                LEG_LOWER: begin
                    if (req_i == REQ_TOP) begin
                        d.st = LEG_GAP; d.tgt = LEG_UPPER; d.cnt = '0;
                    end else if (req_i == REQ_NONE) begin
                        d.st = LEG_IDLE;
                    end
                end
                default: begin
                    if (req_i == REQ_NONE) begin
                        d.st = LEG_IDLE;
                    end else if (req_i != req_of(q.tgt)) begin
                        d.tgt = (req_i == REQ_TOP) ? LEG_UPPER : LEG_LOWER;
                        d.cnt = '0;
                    end else if (gap_done) begin
                        d.st = q.tgt;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            endcase
        end

        d.gt = (d.st == LEG_UPPER);
        d.gb = (d.st == LEG_LOWER);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= LEG_RST;
        end else begin
            q <= d;
        end
    end

    assign mp_o  = q.mp;
    assign gt_o  = q.gt;
    assign gb_o  = q.gb;
    assign flt_o = q.flt;

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl #(
    parameter int LEGS = 3,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LEGS-1:0] cmd_top,
    input  logic [LEGS-1:0] cmd_bot,
    input  logic [CW-1:0]   dead_cnt,
    input  logic [CW-1:0]   min_pulse,
    output logic [LEGS-1:0] gate_top,
    output logic [LEGS-1:0] gate_bot,
    output logic [LEGS-1:0] fault
);

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        logic [1:0]    req;
        logic          bad;
        logic [CW-1:0] mp_held;

        gate_cmd_qual #(.CW(CW)) u_qual (
            .clk   (clk),
            .rst   (rst),
            .raw_i ({cmd_top[g], cmd_bot[g]}),
            .min_i (mp_held),
            .req_o (req),
            .bad_o (bad)
        );

        gate_leg_fsm #(.CW(CW)) u_fsm (
            .clk   (clk),
            .rst   (rst),
            .req_i (req),
            .bad_i (bad),
            .dt_i  (dead_cnt),
            .mp_i  (min_pulse),
            .mp_o  (mp_held),
            .gt_o  (gate_top[g]),
            .gb_o  (gate_bot[g]),
            .flt_o (fault[g])
        );
    end

endmodule

// File: rtl/gate_ctrl_chk.sv
module gate_ctrl_chk #(
    parameter int LEGS = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [LEGS-1:0] cmd_top,
    input logic [LEGS-1:0] cmd_bot,
    input logic [LEGS-1:0] gate_top,
    input logic [LEGS-1:0] gate_bot,
    input logic [LEGS-1:0] fault
);

    // R1
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_top & gate_bot) == '0);

    // R2
    handover_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(gate_top) & gate_bot) | ($past(gate_bot) & gate_top)) == '0);

    // R5
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fault) & ~fault) == '0);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (gate_top == '0 && gate_bot == '0 && fault == '0));

    for (genvar g = 0; g < LEGS; g++) begin : g_chk
        // R4
        illegal_block_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd_top[g] && cmd_bot[g]) |=> ##1 (fault[g] && !gate_top[g] && !gate_bot[g]));
    end

endmodule

bind gate_ctrl gate_ctrl_chk #(.LEGS(LEGS)) u_gate_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_top  (cmd_top),
    .cmd_bot  (cmd_bot),
    .gate_top (gate_top),
    .gate_bot (gate_bot),
    .fault    (fault)
);

// File: tb/gate_ctrl_test.sv
module gate_ctrl_test;

    localparam int LEGS = 3;
    localparam int CW   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [LEGS-1:0] cmd_top = '0;
    logic [LEGS-1:0] cmd_bot = '0;
    logic [CW-1:0]   dead_cnt = 8'd4;
    logic [CW-1:0]   min_pulse = 8'd3;
    logic [LEGS-1:0] gate_top;
    logic [LEGS-1:0] gate_bot;
    logic [LEGS-1:0] fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gate_ctrl #(.LEGS(LEGS), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cmd_top(cmd_top), .cmd_bot(cmd_bot),
        .dead_cnt(dead_cnt), .min_pulse(min_pulse),
        .gate_top(gate_top), .gate_bot(gate_bot), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic leg0(input bit t, input bit b);
        cmd_top[0] = t;
        cmd_bot[0] = b;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    initial begin
        bit stay, seen;
        int run_len [LEGS];
        int hold    [LEGS];
        bit exp_flt [LEGS];
        bit any_bad [LEGS];
        bit prev_t  [LEGS];
        bit prev_b  [LEGS];
        int on_need, off_need;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);

        tick(3);
        // R9 reset state
        chk(gate_top == 0 && gate_bot == 0 && fault == 0, "R9",
            int'({gate_top, gate_bot, fault}), 0);
        rst = 1'b0;
        tick(5);

        // R7 / R3: turn-on latency q+1+b = 3+1+4 edges
        leg0(1, 0);
        tick(8);
        chk(gate_top[0] == 0, "R7", gate_top[0], 0);
        tick(1);
        chk(gate_top[0] == 1, "R7", gate_top[0], 1);
        chk(gate_bot[0] == 0, "R3", gate_bot[0], 0);
        chk(gate_top[2:1] == 0 && gate_bot[2:1] == 0, "R3",
            int'({gate_top[2:1], gate_bot[2:1]}), 0);

        // R2 / R8: handover with blanking value changed during conduction
        dead_cnt = 8'd9;
        leg0(0, 1);
        tick(4);
        chk(gate_top[0] == 1, "R2", gate_top[0], 1);
        tick(1);
        chk(gate_top[0] == 0 && gate_bot[0] == 0, "R2",
            int'({gate_top[0], gate_bot[0]}), 0);
        tick(3);
        chk(gate_bot[0] == 0, "R8", gate_bot[0], 0);
        tick(1);
        chk(gate_bot[0] == 1, "R8", gate_bot[0], 1);

        // R7 turn-off latency q+1
        leg0(0, 0);
        tick(4);
        chk(gate_bot[0] == 1, "R7", gate_bot[0], 1);
        tick(1);
        chk(gate_bot[0] == 0, "R7", gate_bot[0], 0);
        tick(2);

        // R8: new blanking value applies after idle
        leg0(1, 0);
        tick(13);
        chk(gate_top[0] == 0, "R8", gate_top[0], 0);
        tick(1);
        chk(gate_top[0] == 1, "R8", gate_top[0], 1);

        // R6: notch of 2 cycles during conduction is ignored
        dead_cnt = 8'd4;
        leg0(0, 0);
        tick(2);
        leg0(1, 0);
        stay = 1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (!gate_top[0]) stay = 0;
        end
        chk(stay, "R6", stay, 1);

        // R6: pulse of 2 cycles from idle is ignored, pulse of 3 accepted
        leg0(0, 0);
        tick(6);
        dead_cnt = 8'd1;
        tick(3);
        leg0(0, 1);
        tick(2);
        leg0(0, 0);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (gate_bot[0]) seen = 1;
        end
        chk(!seen, "R6", seen, 0);
        leg0(0, 1);
        tick(3);
        leg0(0, 0);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (gate_bot[0]) seen = 1;
        end
        chk(seen, "R6", seen, 1);

        // R6: threshold 0 behaves as 1
        min_pulse = 8'd0;
        tick(3);
        leg0(1, 0);
        tick(3);
        chk(gate_top[0] == 0, "R6", gate_top[0], 0);
        tick(1);
        chk(gate_top[0] == 1, "R6", gate_top[0], 1);
        leg0(0, 0);
        min_pulse = 8'd3;
        dead_cnt = 8'd4;
        tick(6);

        // R4 / R5: both commands during conduction
        leg0(1, 0);
        tick(10);
        chk(gate_top[0] == 1, "R4", gate_top[0], 1);
        leg0(1, 1);
        tick(1);
        chk(gate_top[0] == 1 && fault[0] == 0, "R5",
            int'({gate_top[0], fault[0]}), 2);
        tick(1);
        chk(gate_top[0] == 0 && gate_bot[0] == 0, "R4",
            int'({gate_top[0], gate_bot[0]}), 0);
        chk(fault[0] == 1, "R5", fault[0], 1);
        chk(fault[2:1] == 0, "R5", fault[2:1], 0);
        leg0(1, 0);
        tick(8);
        chk(gate_top[0] == 0, "R4", gate_top[0], 0);
        tick(1);
        chk(gate_top[0] == 1, "R4", gate_top[0], 1);
        chk(fault[0] == 1, "R5", fault[0], 1);
        leg0(0, 0);
        tick(6);

        // R9: reset clears the fault
        rst = 1'b1;
        tick(1);
        chk(fault == 0 && gate_top == 0 && gate_bot == 0, "R9",
            int'({fault, gate_top, gate_bot}), 0);
        dead_cnt  = 8'd3;
        min_pulse = 8'd2;
        tick(2);
        rst = 1'b0;
        tick(3);

        // random phase: R1, R2, R3, R5, R7 on all legs
        on_need  = eff(2) + 2 + eff(3);
        off_need = eff(2) + 2;
        for (int l = 0; l < LEGS; l++) begin
            run_len[l] = 100; hold[l] = 0; exp_flt[l] = 0; any_bad[l] = 0;
            prev_t[l] = 0; prev_b[l] = 0;
        end
        for (int c = 0; c < 3000; c++) begin
            tick(1);
            for (int l = 0; l < LEGS; l++) begin
                run_len[l]++;
                if (cmd_top[l] && cmd_bot[l] && run_len[l] >= 2) exp_flt[l] = 1;
                if (gate_top[l] && gate_bot[l])
                    chk(0, "R1", int'({gate_top[l], gate_bot[l]}), 0);
                if ((prev_t[l] && gate_bot[l]) || (prev_b[l] && gate_top[l]))
                    chk(0, "R2", int'({prev_t[l], prev_b[l], gate_top[l], gate_bot[l]}), 0);
                if (cmd_top[l] && !cmd_bot[l] && run_len[l] >= on_need)
                    chk(gate_top[l] && !gate_bot[l], "R3",
                        int'({gate_top[l], gate_bot[l]}), 2);
                if (!cmd_top[l] && cmd_bot[l] && run_len[l] >= on_need)
                    chk(!gate_top[l] && gate_bot[l], "R3",
                        int'({gate_top[l], gate_bot[l]}), 1);
                if (!cmd_top[l] && !cmd_bot[l] && run_len[l] >= off_need)
                    chk(!gate_top[l] && !gate_bot[l], "R7",
                        int'({gate_top[l], gate_bot[l]}), 0);
                if (exp_flt[l] && run_len[l] >= 0 && c % 50 == 0)
                    chk(fault[l] == 1'b1, "R5", fault[l], 1);
                if (!any_bad[l] && c % 50 == 0)
                    chk(fault[l] == 1'b0, "R5", fault[l], 0);
                prev_t[l] = gate_top[l];
                prev_b[l] = gate_bot[l];
            end
            for (int l = 0; l < LEGS; l++) begin
                if (hold[l] == 0) begin
                    logic [1:0] nc;
                    int r;
                    r = int'($urandom_range(0, 15));
                    if (r == 0 && l != 0) nc = 2'b11;
                    else if (r < 6) nc = 2'b10;
                    else if (r < 11) nc = 2'b01;
                    else nc = 2'b00;
                    if (nc == 2'b11) begin
                        any_bad[l] = 1;
                        hold[l] = 1;
                    end else begin
                        hold[l] = int'($urandom_range(1, 12));
                    end
                    if (nc != {cmd_top[l], cmd_bot[l]}) run_len[l] = 0;
                    cmd_top[l] = nc[1];
                    cmd_bot[l] = nc[0];
                end
                hold[l]--;
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule